// File: doc/BRIEF.md
# Numerically Controlled Sine Oscillator Core

This block is a direct digital synthesis core. A 48-bit phase register advances by a frequency tuning word on every sample clock and wraps modulo 2^48, so its average rollover rate sets the output frequency at tuning word × sample rate / 2^48. A 16-bit phase offset is weighted onto the top bits of the phase. The phase is then cut down to 19 bits and turned into a signed 14-bit sine sample, which an external converter can take directly.

The sine conversion uses quarter-wave symmetry. A quarter-period magnitude table is computed while the design elaborates, so no data file is needed. The tuning word and the offset are captured together when a load strobe is high, which means a running output never mixes an old word with a new one. A status output warns when the active tuning word would put the output below one sixteenth of the sample rate.

Top module: `nco_core`

## Requirements
- R1: While `rst` is high at a clock edge, the phase register, the active tuning word and the active offset all clear to zero, and `dout_valid` and `dout` read zero after that edge.
- R2: At every clock edge outside reset, the phase register takes its old value plus the active tuning word, modulo 2^48, with no loss of the remainder when it wraps.
- R3: At an edge where `load` is high, `ftw_in` and `off_in` become the active tuning word and offset, both on the same edge. While `load` is low, changes on `ftw_in` and `off_in` have no effect on the output.
- R4: The active 16-bit offset is added to the phase register with its LSB at phase bit 32, and the sum is taken modulo 2^48.
- R5: The converted phase is bits 47:29 of that sum. Its bits 18:17 give the quadrant, and bits 16:7 index the 1024-entry quarter table.
- R6: Table entry i equals round(8191·sin(π(2i+1)/4096)). In quadrant 0 the output is +T[i]. In quadrant 1 it is +T[1023−i]. In quadrant 2 it is −T[i]. In quadrant 3 it is −T[1023−i].
- R7: The sample that appears after edge k+2 comes from the phase register and offset values held just before edge k. `dout_valid` rises after the third edge following the release of reset and stays high until the next reset.
- R8: `low_rate` is high exactly when the active tuning word is below 2^44.
- R9: A valid sample never takes the value −8192. The output range is symmetric, from −8191 to +8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for the tuning word and the offset |
| ftw_in | input | 48 | Tuning word to be captured |
| off_in | input | 16 | Phase offset to be captured |
| dout | output | 14 | Signed sine sample |
| dout_valid | output | 1 | The sample is valid |
| low_rate | output | 1 | Active tuning word is below 2^44 |

## Verification
A corrupted phase register or a wrong captured word shows up in the sample stream three cycles later, and from then on it changes every sample that follows. The scoreboard therefore compares every valid sample against a bit-exact model of the phase arithmetic. A wrong quadrant decode or a wrong table mirror shows up at once in the fixed-phase tests with a zero tuning word, where each quadrant has a known output value. A capture fault that makes the loaded words drift or tear, or that lets unloaded inputs leak through, breaks the sample match within three cycles of the disturbing stimulus.

// File: rtl/nco_pkg.sv
package nco_pkg;

   localparam real PI_R = 3.14159265358979323846;

   // Quarter-wave magnitude for table slot idx out of n slots, sampled at slot centres.
   function automatic int quarter_sine(input int idx, input int n, input int amp_w);
      real peak;
      real val;
      peak = (2.0 ** (amp_w - 1)) - 1.0;
      val  = peak * $sin(PI_R * (2.0 * idx + 1.0) / (4.0 * n));
      return $rtoi(val + 0.5);
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int ACC_W = 48,
   parameter int OFF_W = 16,
   parameter int PH_W  = 19
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [ACC_W-1:0] ftw_in,
   input  logic [OFF_W-1:0] off_in,
   output logic [ACC_W-1:0] ftw_act,
   output logic [OFF_W-1:0] off_act,
   output logic [ACC_W-1:0] acc,
   output logic [PH_W-1:0]  phase,
   output logic             phase_vld
);
   localparam int PAD_W = ACC_W - OFF_W;

   logic [ACC_W-1:0] ftw_q, acc_q, sum;
   logic [OFF_W-1:0] off_q;
   logic [PH_W-1:0]  phase_q;
   logic             vld_q;

   // Offset weighted onto the most significant phase bits
   generate
      if (PAD_W > 0) begin : g_pad
         assign sum = acc_q + {off_q, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign sum = acc_q + off_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         ftw_q   <= '0;
         off_q   <= '0;
         acc_q   <= '0;
         phase_q <= '0;
         vld_q   <= 1'b0;
      end else begin
         acc_q   <= acc_q + ftw_q;
         phase_q <= sum[ACC_W-1 -: PH_W];
         vld_q   <= 1'b1;
         if (load) begin
            ftw_q <= ftw_in;
            off_q <= off_in;
         end
      end
   end

   assign ftw_act   = ftw_q;
   assign off_act   = off_q;
   assign acc       = acc_q;
   assign phase     = phase_q;
   assign phase_vld = vld_q;
endmodule

// File: rtl/nco_sine_lut.sv
module nco_sine_lut
   import nco_pkg::*;
#(
   parameter int PH_W   = 19,
   parameter int AMP_W  = 14,
   parameter int LUT_AW = 10
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [PH_W-1:0]         phase,
   input  logic                    phase_vld,
   output logic signed [AMP_W-1:0] dout,
   output logic                    dout_valid
);
   localparam int N     = 1 << LUT_AW;
   localparam int MAG_W = AMP_W - 1;
   localparam int FRAC  = PH_W - 2;

   logic [MAG_W-1:0]  qtab [N];
   logic [1:0]        quad;
   logic [LUT_AW-1:0] idx, addr;
   logic [MAG_W-1:0]  mag_q;
   logic              neg_q, vld2_q, vld3_q;
   logic signed [AMP_W-1:0] dout_q;

   generate
      for (genvar i = 0; i < N; i++) begin : g_tab
         assign qtab[i] = MAG_W'(quarter_sine(i, N, AMP_W));
      end
      if (LUT_AW == FRAC) begin : g_full_idx
         assign idx = phase[FRAC-1:0];
      end else begin : g_trunc_idx
         assign idx = phase[FRAC-1 -: LUT_AW];
      end
   endgenerate

   assign quad = phase[PH_W-1 -: 2];
   assign addr = quad[0] ? ~idx : idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         mag_q  <= '0;
         neg_q  <= 1'b0;
         vld2_q <= 1'b0;
         dout_q <= '0;
         vld3_q <= 1'b0;
      end else begin
         mag_q  <= qtab[addr];
         neg_q  <= quad[1];
         vld2_q <= phase_vld;
         dout_q <= neg_q ? -$signed({1'b0, mag_q}) : $signed({1'b0, mag_q});
         vld3_q <= vld2_q;
      end
   end

   assign dout       = dout_q;
   assign dout_valid = vld3_q;
endmodule

// File: rtl/nco_core.sv
module nco_core #(
   parameter int ACC_W     = 48,
   parameter int OFF_W     = 16,
   parameter int PH_W      = 19,
   parameter int AMP_W     = 14,
   parameter int LUT_AW    = 10,
   parameter int LOW_SHIFT = 4
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load,
   input  logic [ACC_W-1:0]        ftw_in,
   input  logic [OFF_W-1:0]        off_in,
   output logic signed [AMP_W-1:0] dout,
   output logic                    dout_valid,
   output logic                    low_rate
);
   logic [ACC_W-1:0] ftw_act, acc;
   logic [OFF_W-1:0] off_act;
   logic [PH_W-1:0]  phase;
   logic             phase_vld;

   generate
      if (OFF_W > ACC_W || PH_W > ACC_W) begin : g_bad_w
         $error("offset and phase widths must not exceed the accumulator width");
      end
      if (PH_W < 3 || LUT_AW < 1 || LUT_AW > PH_W - 2) begin : g_bad_lut
         $error("table index must fit below the quadrant bits");
      end
      if (AMP_W < 2 || LUT_AW > 12) begin : g_bad_amp
         $error("amplitude or table size out of supported range");
      end
      if (LOW_SHIFT < 1 || LOW_SHIFT >= ACC_W) begin : g_bad_low
         $error("low-rate threshold shift out of range");
      end
   endgenerate

   nco_phase_acc #(.ACC_W(ACC_W), .OFF_W(OFF_W), .PH_W(PH_W)) u_acc (
      .clk(clk), .rst(rst), .load(load), .ftw_in(ftw_in), .off_in(off_in),
      .ftw_act(ftw_act), .off_act(off_act), .acc(acc),
      .phase(phase), .phase_vld(phase_vld)
   );

   nco_sine_lut #(.PH_W(PH_W), .AMP_W(AMP_W), .LUT_AW(LUT_AW)) u_lut (
      .clk(clk), .rst(rst), .phase(phase), .phase_vld(phase_vld),
      .dout(dout), .dout_valid(dout_valid)
   );

   // Threshold 2^(ACC_W-LOW_SHIFT): top LOW_SHIFT bits all zero
   assign low_rate = ~|ftw_act[ACC_W-1 -: LOW_SHIFT];
endmodule

// File: rtl/nco_core_chk.sv
module nco_core_chk #(
   parameter int ACC_W = 48,
   parameter int OFF_W = 16,
   parameter int AMP_W = 14
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    load,
   input logic [ACC_W-1:0]        ftw_in,
   input logic [OFF_W-1:0]        off_in,
   input logic [ACC_W-1:0]        ftw_act,
   input logic [OFF_W-1:0]        off_act,
   input logic [ACC_W-1:0]        acc,
   input logic signed [AMP_W-1:0] dout,
   input logic                    dout_valid
);
   logic rst_d;
   always_ff @(posedge clk) rst_d <= rst;

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (rst)
      rst_d |-> (acc == '0 && ftw_act == '0 && off_act == '0 && !dout_valid && dout == '0));

   // R2
   acc_step_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> acc == ACC_W'($past(acc) + $past(ftw_act)));

   // R3
   load_take_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> (ftw_act == $past(ftw_in) && off_act == $past(off_in)));

   // R3
   hold_words_chk: assert property (@(posedge clk) disable iff (rst)
      !load |=> ($stable(ftw_act) && $stable(off_act)));

   // R7
   valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      dout_valid |=> dout_valid);

   // R9
   no_min_code_chk: assert property (@(posedge clk) disable iff (rst)
      dout_valid |-> dout != {1'b1, {(AMP_W-1){1'b0}}});
endmodule

bind nco_core nco_core_chk #(.ACC_W(ACC_W), .OFF_W(OFF_W), .AMP_W(AMP_W)) u_chk (
   .clk(clk), .rst(rst), .load(load), .ftw_in(ftw_in), .off_in(off_in),
   .ftw_act(ftw_act), .off_act(off_act), .acc(acc),
   .dout(dout), .dout_valid(dout_valid)
);

// File: tb/nco_core_bench.sv
module nco_core_bench;
   localparam real PI_B = 3.14159265358979323846;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               load = 1'b0;
   logic [47:0]        ftw_in = '0;
   logic [15:0]        off_in = '0;
   logic signed [13:0] dout;
   logic               dout_valid, low_rate;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   logic [47:0] m_acc = '0, m_ftw = '0;
   logic [15:0] m_off = '0;
   logic signed [13:0] sb_q [$];

   always #10 clk = ~clk;

   nco_core u_nco_core (
      .clk(clk), .rst(rst), .load(load), .ftw_in(ftw_in), .off_in(off_in),
      .dout(dout), .dout_valid(dout_valid), .low_rate(low_rate)
   );

   function automatic int tab(input int i);
      real v;
      v = 8191.0 * $sin(PI_B * (2.0 * i + 1.0) / (4.0 * 1024));
      return $rtoi(v + 0.5);
   endfunction

   // R4 R5 R6: expected sample from phase register and offset
   function automatic logic signed [13:0] expect_sample(input logic [47:0] a, input logic [15:0] o);
      logic [47:0] s;
      logic [18:0] ph;
      logic [9:0]  i;
      int m;
      s  = a + {o, 32'h0};
      ph = s[47:29];
      i  = ph[16:7];
      if (ph[17]) i = 10'd1023 - i;
      m  = tab(int'(i));
      return ph[18] ? 14'(-m) : 14'(m);
   endfunction

   // Driver-side model: pushes expected items (R2 R3 R7)
   always @(posedge clk) begin
      if (rst) begin
         m_acc = '0; m_ftw = '0; m_off = '0;
         sb_q.delete();
      end else begin
         sb_q.push_back(expect_sample(m_acc, m_off));
         m_acc = m_acc + m_ftw;
         if (load) begin
            m_ftw = ftw_in;
            m_off = off_in;
         end
      end
   end

   // Monitor: pops and compares
   always @(negedge clk) begin
      if (!rst && dout_valid && !done) begin
         checks++;
         if (sb_q.size() == 0) begin
            fails++;
            $display("FAIL R7 sample with empty scoreboard: actual %0d expected none", dout);
         end else begin
            logic signed [13:0] e;
            e = sb_q.pop_front();
            if (dout !== e) begin
               fails++;
               $display("FAIL R2 R6 R7 sample mismatch: actual %0d expected %0d", dout, e);
            end
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_load(input logic [47:0] f, input logic [15:0] o);
      @(negedge clk);
      ftw_in = f; off_in = o; load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   initial begin
      cycles(5);
      // R1
      check("R1 valid after reset", 32'(dout_valid), 0);
      check("R1 sample after reset", 32'(dout), 0);
      check("R8 low_rate with zero word", 32'(low_rate), 1);
      rst = 1'b0;
      cycles(2);
      check("R7 valid not yet high", 32'(dout_valid), 0);
      cycles(1);
      check("R7 valid after third edge", 32'(dout_valid), 1);

      // Fixed phases, one per quadrant (R6)
      do_load('0, 16'h0000); cycles(5);
      check("R6 quadrant 0", 32'(int'(dout)), 32'(6));
      do_load('0, 16'h4000); cycles(5);
      check("R6 quadrant 1", 32'(int'(dout)), 32'(8191));
      do_load('0, 16'h8000); cycles(5);
      check("R6 quadrant 2", 32'(int'(dout)), 32'(-6));
      do_load('0, 16'hC000); cycles(5);
      check("R6 R9 quadrant 3", 32'(int'(dout)), 32'(-8191));

      // Running tone with offset (R2 R4)
      do_load(48'h27D0_28A1_DFB9, 16'h1234);
      cycles(300);
      check("R8 low_rate off at high rate", 32'(low_rate), 0);

      // Inputs move without load (R3)
      ftw_in = 48'h0000_0000_1111; off_in = 16'hABCD;
      cycles(60);

      // Threshold edges (R8)
      do_load(48'h0FFF_FFFF_FFFF, 16'h0);
      cycles(1);
      check("R8 just below threshold", 32'(low_rate), 1);
      cycles(40);
      do_load(48'h1000_0000_0000, 16'h0);
      cycles(1);
      check("R8 at threshold", 32'(low_rate), 0);
      cycles(40);

      // Wrap with a near-full word (R2)
      do_load(48'hFFFF_FFFF_FFFB, 16'h8001);
      cycles(200);
      for (int k = 0; k < 6; k++) begin
         do_load({$urandom(), 16'($urandom())}, 16'($urandom()));
         cycles(80);
      end

      // Reset in mid-run (R1)
      @(negedge clk); rst = 1'b1;
      cycles(3);
      check("R1 valid cleared in mid-run", 32'(dout_valid), 0);
      check("R1 sample cleared in mid-run", 32'(dout), 0);
      check("R1 R8 active word cleared", 32'(low_rate), 1);
      rst = 1'b0;
      do_load(48'h0123_4567_89AB, 16'h7777);
      cycles(100);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule